// File: doc/BRIEF.md
# Configurable Output Macrocell

One output cell of a sum-of-products logic device. The cell takes a group of product terms from the shared AND plane, ORs them, and applies a per-cell polarity choice. A two-bit architecture code then decides what the cell does:

- It can store the sum in a D register, driven out through an inverting buffer.
- It can pass the sum straight to a bidirectional pin.
- It can give up its pin to be a plain input.
- It can drive its pin all the time with the feedback path turned off.

The cell returns a feedback bit to the AND plane. That bit is either the register state or the level seen on the pin, depending on the mode.

The register has an asynchronous clear term and a synchronous set term. Both are shared by all cells. A synchronous power-up reset leaves the register at 0, so the pin reads high in registered mode whatever the polarity. A test request can load the register from the value applied on its pin. While that request is high, the cell's driver is off. The pad itself is modelled as a drive value, an enable, and a sensed input.

Top module: `omc_cell`

## Requirements
- R1: In registered mode (arch_mode 2'b00), each rising clock edge with no reset, clear, set or preload active stores the sum, so that from the next edge the pin shows OR(sum_terms) when pol_true is 1 and its inverse when pol_true is 0.
- R2: In registered mode, pin_oe follows glob_oe, and fb_out is the register state, which is always the inverse of pin_out.
- R3: In bidirectional mode (arch_mode 2'b01), pin_out is the polarity-adjusted sum with no clock delay. pin_oe equals dir_term, and fb_out equals pin_in.
- R4: In fixed-input mode (arch_mode 2'b10), pin_oe is 0 and fb_out equals pin_in. pin_out still carries the polarity-adjusted sum.
- R5: In fixed-output mode (arch_mode 2'b11), pin_oe is 1 and fb_out is held at 0. pin_out is the polarity-adjusted sum.
- R6: While rst is high at a rising edge, the register is cleared to 0. In registered mode the pin then reads 1 for either polarity.
- R7: A high clr_term clears the register at once, without waiting for a clock edge. It wins over set_term at the same edge.
- R8: set_term makes the register 1 only at the next rising edge, which makes a registered pin read 0.
- R9: While preload_req is high, pin_oe is 0 in every mode, and each rising edge loads the register with pin_in. Once the request drops, fb_out holds the loaded value and pin_out holds its inverse until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| arch_mode | input | 2 | Architecture code: 00 registered, 01 bidirectional, 10 fixed input, 11 fixed output |
| pol_true | input | 1 | 1 = non-inverting, 0 = inverting (erased default) |
| sum_terms | input | N_TERMS | Product terms ORed into the cell's sum |
| dir_term | input | 1 | Direction product term (pin enable in bidirectional mode) |
| glob_oe | input | 1 | Shared output enable for registered cells |
| clr_term | input | 1 | Shared asynchronous clear term |
| set_term | input | 1 | Shared synchronous set term |
| preload_req | input | 1 | Test request to load the register from the pin |
| pin_in | input | 1 | Level sensed on the pad |
| pin_out | output | 1 | Value driven onto the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback bit returned to the AND plane |

## Verification
The embedded properties watch, on every edge, several rules:

- Clear always leaves the register empty, and reset leaves it at 0.
- Set yields a 1 at the next edge unless a clear intervenes.
- Preload copies the pin into the register.
- The fixed-input and preload conditions keep the driver off, and fixed-output keeps it on with a dead feedback.
- The registered pin is always the inverse of its feedback.

Only the bench's scenarios show the following:

- The one-cycle lag of the registered sum.
- The polarity mapping in each mode.
- That a clear acts before any edge arrives.
- That a set stays invisible until its edge.
- What the pin and feedback read back right after a preload ends.

// File: rtl/omc_pkg.sv
package omc_pkg;

    typedef enum logic [1:0] {
        ARCH_REG    = 2'b00,
        ARCH_BIDIR  = 2'b01,
        ARCH_FIXIN  = 2'b10,
        ARCH_FIXOUT = 2'b11
    } arch_e;

    typedef struct packed {
        logic drive;
        logic en;
        logic fb;
    } pad_view_t;

    function automatic logic apply_pol(input logic s, input logic keep);
        return keep ? s : ~s;
    endfunction

endpackage

// File: rtl/omc_sum.sv
module omc_sum #(
    parameter int N_TERMS = 8
) (
    input  logic [N_TERMS-1:0] terms,
    input  logic               pol_true,
    output logic               comb_val,
    output logic               d_val
);
    import omc_pkg::*;

    localparam int LAST = N_TERMS - 1;

    logic [LAST:0] chain;

    genvar g;
    generate
        for (g = 0; g < N_TERMS; g++) begin : g_or
            if (g == 0) begin : g_first
                assign chain[g] = terms[g];
            end else begin : g_rest
                assign chain[g] = chain[g-1] | terms[g];
            end
        end
    endgenerate

    always_comb begin
        comb_val = apply_pol(chain[LAST], pol_true);
        // register feeds an inverting buffer, so store the complement
        d_val    = ~comb_val;
    end

endmodule

// File: rtl/omc_store.sv
module omc_store (
    input  logic clk,
    input  logic rst,
    input  logic clr_term,
    input  logic set_term,
    input  logic preload,
    input  logic pin_in,
    input  logic d_val,
    output logic q
);

    always_ff @(posedge clk or posedge clr_term) begin
        if (clr_term)     q <= 1'b0;
        else if (rst)     q <= 1'b0;
        else if (preload) q <= pin_in;
        else if (set_term) q <= 1'b1;
        else              q <= d_val;
    end

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
        clr_term |-> (q == 1'b0));

    p_set_next_edge_r8: assert property (@(posedge clk) disable iff (rst)
        (set_term && !clr_term && !preload) |=> (q || clr_term));

    p_preload_copies_r9: assert property (@(posedge clk) disable iff (rst)
        (preload && !clr_term) |=> ((q == $past(pin_in)) || clr_term));

    p_reset_clears_r6: assert property (@(posedge clk) disable iff (clr_term)
        rst |=> (q == 1'b0));

endmodule

// File: rtl/omc_route.sv
module omc_route (
    input  logic             clk,
    input  logic             rst,
    input  omc_pkg::arch_e   mode,
    input  logic             q,
    input  logic             comb_val,
    input  logic             dir_term,
    input  logic             glob_oe,
    input  logic             preload,
    input  logic             pin_in,
    output omc_pkg::pad_view_t pad
);
    import omc_pkg::*;

    pad_view_t base;

    always_comb begin
        unique case (mode)
            ARCH_REG:    base = '{drive: ~q,       en: glob_oe,  fb: q};
            ARCH_BIDIR:  base = '{drive: comb_val, en: dir_term, fb: pin_in};
            ARCH_FIXIN:  base = '{drive: comb_val, en: 1'b0,     fb: pin_in};
            default:     base = '{drive: comb_val, en: 1'b1,     fb: 1'b0};
        endcase
        pad    = base;
        pad.en = base.en & ~preload;
    end

    p_driver_off_r4_r9: assert property (@(posedge clk) disable iff (rst)
        (preload || mode == ARCH_FIXIN) |-> !pad.en);

    p_fixed_out_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == ARCH_FIXOUT && !preload) |-> (pad.en && !pad.fb));

    p_reg_inverts_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == ARCH_REG) |-> (pad.drive != pad.fb));

endmodule

// File: rtl/omc_cell.sv
module omc_cell #(
    parameter int N_TERMS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         arch_mode,
    input  logic               pol_true,
    input  logic [N_TERMS-1:0] sum_terms,
    input  logic               dir_term,
    input  logic               glob_oe,
    input  logic               clr_term,
    input  logic               set_term,
    input  logic               preload_req,
    input  logic               pin_in,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               fb_out
);
    import omc_pkg::*;

    logic      comb_val;
    logic      d_val;
    logic      q;
    pad_view_t pad;
    arch_e     mode;

    assign mode = arch_e'(arch_mode);

    omc_sum #(.N_TERMS(N_TERMS)) u_sum (
        .terms    (sum_terms),
        .pol_true (pol_true),
        .comb_val (comb_val),
        .d_val    (d_val)
    );

    omc_store u_store (
        .clk      (clk),
        .rst      (rst),
        .clr_term (clr_term),
        .set_term (set_term),
        .preload  (preload_req),
        .pin_in   (pin_in),
        .d_val    (d_val),
        .q        (q)
    );

    omc_route u_route (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .q        (q),
        .comb_val (comb_val),
        .dir_term (dir_term),
        .glob_oe  (glob_oe),
        .preload  (preload_req),
        .pin_in   (pin_in),
        .pad      (pad)
    );

    assign pin_out = pad.drive;
    assign pin_oe  = pad.en;
    assign fb_out  = pad.fb;

endmodule

// File: tb/omc_cell_bench.sv
module omc_cell_bench;

    localparam int N_TERMS = 8;

    logic               clk = 1'b0;
    logic               rst;
    logic [1:0]         arch_mode;
    logic               pol_true;
    logic [N_TERMS-1:0] sum_terms;
    logic               dir_term, glob_oe, clr_term, set_term, preload_req, pin_in;
    logic               pin_out, pin_oe, fb_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    omc_cell #(.N_TERMS(N_TERMS)) u_omc_cell (
        .clk(clk), .rst(rst), .arch_mode(arch_mode), .pol_true(pol_true),
        .sum_terms(sum_terms), .dir_term(dir_term), .glob_oe(glob_oe),
        .clr_term(clr_term), .set_term(set_term), .preload_req(preload_req),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    // {mode[1:0], pol, sum_any, dir, pin, exp_out, exp_oe, exp_fb}
    localparam logic [8:0] VEC [8] = '{
        9'b01_1_1_1_0_1_1_0,
        9'b01_0_1_0_1_0_0_1,
        9'b01_0_0_1_0_1_1_0,
        9'b10_1_1_1_1_1_0_1,
        9'b10_0_1_0_0_0_0_0,
        9'b11_1_0_0_1_0_1_0,
        9'b11_0_0_1_1_1_1_0,
        9'b11_1_1_0_0_1_1_0
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; arch_mode = 2'b00; pol_true = 1'b1; sum_terms = '0;
        dir_term = 1'b0; glob_oe = 1'b1; clr_term = 1'b0; set_term = 1'b0;
        preload_req = 1'b0; pin_in = 1'b0;
        repeat (3) tick();
        // R6: reset holds register at 0 although D would be 1
        chk("R6", "pin_out in reset pol=1", pin_out, 1'b1);
        chk("R6", "fb_out in reset", fb_out, 1'b0);
        pol_true = 1'b0; #1;
        chk("R6", "pin_out in reset pol=0", pin_out, 1'b1);

        // combinational modes from table
        for (int i = 0; i < 8; i++) begin
            logic [8:0] v;
            string      tag;
            v = VEC[i];
            @(negedge clk);
            arch_mode = v[8:7]; pol_true = v[6];
            sum_terms = v[5] ? (N_TERMS'(1) << (i % N_TERMS)) : '0;
            dir_term = v[4]; pin_in = v[3];
            #1;
            tag = (v[8:7] == 2'b01) ? "R3" : (v[8:7] == 2'b10) ? "R4" : "R5";
            chk(tag, "pin_out", pin_out, v[2]);
            chk(tag, "pin_oe",  pin_oe,  v[1]);
            chk(tag, "fb_out",  fb_out,  v[0]);
        end

        // registered mode
        @(negedge clk);
        arch_mode = 2'b00; glob_oe = 1'b1; pol_true = 1'b1; sum_terms = '0;
        rst = 1'b1; tick();
        @(negedge clk); rst = 1'b0;
        tick();
        chk("R1", "pin_out sum=0 pol=1", pin_out, 1'b0);
        chk("R2", "fb_out is register", fb_out, 1'b1);
        @(negedge clk); sum_terms = 8'h04;
        #1 chk("R1", "pin_out before edge", pin_out, 1'b0);
        tick();
        chk("R1", "pin_out sum=1 pol=1", pin_out, 1'b1);
        chk("R2", "fb_out after sum=1", fb_out, 1'b0);
        @(negedge clk); pol_true = 1'b0;
        tick();
        chk("R1", "pin_out sum=1 pol=0", pin_out, 1'b0);
        @(negedge clk); glob_oe = 1'b0;
        #1 chk("R2", "pin_oe glob_oe=0", pin_oe, 1'b0);
        glob_oe = 1'b1;
        #1 chk("R2", "pin_oe glob_oe=1", pin_oe, 1'b1);

        // synchronous set
        @(negedge clk); sum_terms = '0;
        tick();
        chk("R1", "pin_out sum=0 pol=0", pin_out, 1'b1);
        @(negedge clk); set_term = 1'b1;
        #1 chk("R8", "pin_out before edge", pin_out, 1'b1);
        tick();
        chk("R8", "pin_out after set", pin_out, 1'b0);
        chk("R8", "fb_out after set", fb_out, 1'b1);

        // asynchronous clear
        @(negedge clk); set_term = 1'b0; clr_term = 1'b1;
        #1 chk("R7", "fb_out before edge", fb_out, 1'b0);
        chk("R7", "pin_out before edge", pin_out, 1'b1);
        set_term = 1'b1;
        tick();
        chk("R7", "fb_out clear beats set", fb_out, 1'b0);
        @(negedge clk); clr_term = 1'b0; set_term = 1'b0;

        // preload
        @(negedge clk); preload_req = 1'b1; pin_in = 1'b1;
        #1 chk("R9", "pin_oe during preload", pin_oe, 1'b0);
        tick();
        @(negedge clk); preload_req = 1'b0; pin_in = 1'b0;
        #1 chk("R9", "fb_out after preload", fb_out, 1'b1);
        chk("R9", "pin_out after preload", pin_out, 1'b0);
        chk("R9", "pin_oe after preload", pin_oe, 1'b1);
        @(negedge clk); arch_mode = 2'b01; dir_term = 1'b1; preload_req = 1'b1;
        #1 chk("R9", "pin_oe preload bidir", pin_oe, 1'b0);
        @(negedge clk); preload_req = 1'b0;
        #1 chk("R3", "pin_oe bidir dir=1", pin_oe, 1'b1);

        finish_run();
    end

endmodule